// File: doc/BRIEF.md
# Rotating Priority Interrupt Controller Core

This block arbitrates eight interrupt request lines for a processor. Requests arrive as an 8-bit vector and are held in a pending register until they are taken. A mask register can block any line, and an in-service register records which lines the processor is currently handling. The block raises its interrupt output when the best unmasked pending line ranks strictly above the best line in service. Rank is measured from a programmable rotation offset, so the line that has most recently been serviced can be moved to the bottom of the order.

Software programs the block through a byte-wide register port with two addresses. Address 0 takes the word that starts initialisation and the runtime command words. Address 1 takes the initialisation data words and, in normal operation, the mask. Command words close an in-service level (by line number or by rank), rotate the priority order, choose which register a read from address 0 returns, and arm a poll read. A poll read hands back the signalled line and retires it. The processor acknowledges an interrupt with a one-cycle strobe, during which the block presents the vector number (base plus line).

Initialisation is a sequence of two to four words. A single-controller option skips the cascade word, and an optional fourth word can turn on special fully nested mode. In that mode a controller built as the primary leaves its cascade line out of the in-service side of the priority comparison.

Top module: `prioIrqCore`

## Requirements
- R1: After reset the interrupt output is low, and the pending, in-service and mask registers read as zero. The rotation offset is 0 and the block is in normal operation.
- R2: A 1 on bit i of the request vector at a clock edge sets pending bit i. The bit stays set until an acknowledge or a poll read takes that line. Reads from address 0 return the pending register while the read select is 0.
- R3: Line i has rank (i - offset) mod 8, and rank 0 is the highest. The output is high exactly when some unmasked pending line exists and the best such line has a strictly smaller rank than the best in-service line, or when no line is in service.
- R4: In normal operation a write to address 1 loads the mask register. A masked line never raises the output. A read from address 1 returns the mask.
- R5: An acknowledge strobe while the output is high sets the in-service bit of the signalled line and clears its pending bit. During the strobe the vector output is the base with the line in bits 2:0. An acknowledge while the output is low presents base plus 7 and changes no register.
- R6: A write to address 0 with bit 4 = 0, bit 3 = 1 and bit 1 = 1 copies bit 0 into the read select. 0 selects the pending register and 1 selects the in-service register.
- R7: A command with bit 4 = 0, bit 3 = 0 and bits 7:5 = 3 clears the in-service bit named by bits 2:0. Code 7 does the same and also sets the offset to that line plus 1, mod 8.
- R8: Command code 6 sets the offset to bits 2:0 plus 1, mod 8. It leaves the in-service register unchanged.
- R9: Command code 1 clears the best-ranked in-service bit. Code 5 does the same and also sets the offset to that line plus 1. With nothing in service, neither command changes anything.
- R10: A write to address 0 with bit 4 = 0, bit 3 = 1 and bit 2 = 1 arms a poll. The next read returns the signalled line, clears that line's pending and in-service bits, and disarms the poll. If the output is low, the read returns 0x07 and changes nothing else.
- R11: A write to address 0 with bit 4 = 1 clears pending, in-service, mask, offset, base, read select and special fully nested mode. It drops the output. It records bit 0 as "fourth word follows" and bit 1 as single mode.
- R12: After R11, the next write to address 1 sets the base to the data AND 0xF8. Next comes a cascade word unless single mode is set, then a fourth word if one was requested, then normal operation. Address 1 words consumed by this sequence do not load the mask.
- R13: Bit 4 of the fourth word enables special fully nested mode. On the primary controller, in-service bit 2 is then ignored when the output is decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 8 | Request vector; each 1 sets the matching pending bit |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | Register address (0 command, 1 data) |
| wrData | input | 8 | Write data byte |
| rdEn | input | 1 | Register read strobe (completes an armed poll) |
| rdData | output | 8 | Read data, combinational |
| ackIn | input | 1 | Interrupt acknowledge strobe |
| intVector | output | 8 | Vector number, valid while ackIn is high |
| intOut | output | 1 | Interrupt request to the processor |

## Verification
Register writes, requests and acknowledges take effect at the clock edge that samples them. The output, and any later read, reflects the new state from that edge on. The bench therefore drives each stimulus just after a falling edge and releases it at the next falling edge, so exactly one rising edge falls in between. It then samples the output at that second falling edge. Read data and the acknowledge vector are combinational from the current state. They are sampled 1 ns after the strobe is raised, before the edge at which a poll read or an acknowledge retires the line. The sweeps cover every offset, in-service line and pending line, and every mask value, with expected ranks computed as (line - offset) mod 8.

// File: rtl/prioIrqPkg.sv
`timescale 1ns/1ps
package prioIrqPkg;
  localparam int NUM_LINES = 8;
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'(NUM_LINES - 1);

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_BASE   = 2'd1,
    ST_CASC   = 2'd2,
    ST_FOURTH = 2'd3
  } seqStateT;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic              initClr;
    logic              maskLoad;
    logic              clrIsrLine;
    logic              clrIsrBest;
    logic              rotLine;
    logic              rotBest;
    logic              takeReq;
    logic              dropReq;
    logic [LINE_W-1:0] line;
    logic [DATA_W-1:0] data;
  } strobeT;
endpackage

// File: rtl/prioIrqScan.sv
`timescale 1ns/1ps
module prioIrqScan #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] vec,
  input  logic [W-1:0] offset,
  output logic         valid,
  output logic [W-1:0] line,
  output logic [W-1:0] rank
);
  logic [W-1:0] idx;

  // walk from lowest rank last so the best hit wins
  always_comb begin
    valid = 1'b0;
    line  = '0;
    rank  = '0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = offset + W'(k);
      if (vec[idx]) begin
        valid = 1'b1;
        line  = idx;
        rank  = W'(k);
      end
    end
  end
endmodule

// File: rtl/prioIrqCtrl.sv
`timescale 1ns/1ps
module prioIrqCtrl
  import prioIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              ackIn,
  output strobeT            stb,
  output logic              rdSelIsr,
  output logic              pollActive,
  output logic [DATA_W-1:0] baseQ,
  output logic              sfnMode
);
  seqStateT state;
  logic     fourthWanted;
  logic     singleMode;
  logic     pollArm;
  logic     initWr;
  logic     cmdWr;
  logic     opWr;
  logic [2:0] opCode;

  assign initWr     = wrEn && !addr && wrData[4];
  assign cmdWr      = wrEn && !addr && !wrData[4] && wrData[3];
  assign opWr       = wrEn && !addr && !wrData[4] && !wrData[3];
  assign opCode     = wrData[7:5];
  assign pollActive = pollArm && rdEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_RUN;
      fourthWanted <= 1'b0;
      singleMode   <= 1'b0;
      sfnMode      <= 1'b0;
      baseQ        <= '0;
      rdSelIsr     <= 1'b0;
      pollArm      <= 1'b0;
    end else begin
      if (pollActive) pollArm <= 1'b0;
      if (initWr) begin
        state        <= ST_BASE;
        fourthWanted <= wrData[0];
        singleMode   <= wrData[1];
        sfnMode      <= 1'b0;
        baseQ        <= '0;
        rdSelIsr     <= 1'b0;
        pollArm      <= 1'b0;
      end else if (cmdWr) begin
        if (wrData[2]) pollArm <= 1'b1;
        if (wrData[1]) rdSelIsr <= wrData[0];
      end else if (wrEn && addr) begin
        case (state)
          ST_BASE: begin
            baseQ <= wrData & BASE_MASK;
            if (!singleMode)      state <= ST_CASC;
            else if (fourthWanted) state <= ST_FOURTH;
            else                  state <= ST_RUN;
          end
          ST_CASC:   state <= fourthWanted ? ST_FOURTH : ST_RUN;
          ST_FOURTH: begin
            sfnMode <= wrData[4];
            state   <= ST_RUN;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.line     = wrData[LINE_W-1:0];
    stb.data     = wrData;
    stb.initClr  = initWr;
    stb.maskLoad = wrEn && addr && (state == ST_RUN);
    stb.takeReq  = ackIn;
    stb.dropReq  = pollActive;
    if (opWr) begin
      case (opCode)
        3'd1: stb.clrIsrBest = 1'b1;
        3'd5: begin
          stb.clrIsrBest = 1'b1;
          stb.rotBest    = 1'b1;
        end
        3'd3: stb.clrIsrLine = 1'b1;
        3'd7: begin
          stb.clrIsrLine = 1'b1;
          stb.rotLine    = 1'b1;
        end
        3'd6: stb.rotLine = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prioIrqDatapath.sv
`timescale 1ns/1ps
module prioIrqDatapath
  import prioIrqPkg::*;
#(
  parameter bit IS_PRIMARY   = 1'b1,
  parameter int CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  strobeT               stb,
  input  logic                 sfnMode,
  output logic [NUM_LINES-1:0] pendQ,
  output logic [NUM_LINES-1:0] isrQ,
  output logic [NUM_LINES-1:0] maskQ,
  output logic                 hit,
  output logic [LINE_W-1:0]    hitLine
);
  logic [LINE_W-1:0]    offsetQ;
  logic [NUM_LINES-1:0] isrGated;
  logic                 pendV, isrV, rawV;
  logic [LINE_W-1:0]    pendLine, isrLine, rawLine;
  logic [LINE_W-1:0]    pendRank, isrRank, rawRank;
  logic [NUM_LINES-1:0] pendN, isrN, maskN;
  logic [LINE_W-1:0]    offsetN;

  generate
    if (IS_PRIMARY) begin : gPrimary
      assign isrGated = isrQ & ~(NUM_LINES'(sfnMode) << CASCADE_LINE);
    end else begin : gSecondary
      assign isrGated = isrQ;
    end
  endgenerate

  prioIrqScan #(.N(NUM_LINES), .W(LINE_W)) uPendScan (
    .vec(pendQ & ~maskQ), .offset(offsetQ),
    .valid(pendV), .line(pendLine), .rank(pendRank)
  );
  prioIrqScan #(.N(NUM_LINES), .W(LINE_W)) uIsrScan (
    .vec(isrGated), .offset(offsetQ),
    .valid(isrV), .line(isrLine), .rank(isrRank)
  );
  prioIrqScan #(.N(NUM_LINES), .W(LINE_W)) uRawScan (
    .vec(isrQ), .offset(offsetQ),
    .valid(rawV), .line(rawLine), .rank(rawRank)
  );

  assign hit     = pendV && (!isrV || (pendRank < isrRank));
  assign hitLine = pendLine;

  always_comb begin
    pendN   = pendQ;
    isrN    = isrQ;
    maskN   = maskQ;
    offsetN = offsetQ;
    if (stb.takeReq && hit) begin
      isrN[hitLine]  = 1'b1;
      pendN[hitLine] = 1'b0;
    end
    if (stb.dropReq && hit) begin
      isrN[hitLine]  = 1'b0;
      pendN[hitLine] = 1'b0;
    end
    if (stb.clrIsrLine) isrN[stb.line] = 1'b0;
    if (stb.clrIsrBest && rawV) isrN[rawLine] = 1'b0;
    if (stb.rotLine) offsetN = stb.line + 1'b1;
    if (stb.rotBest && rawV) offsetN = rawLine + 1'b1;
    if (stb.maskLoad) maskN = stb.data[NUM_LINES-1:0];
    pendN = pendN | reqIn;
    if (stb.initClr) begin
      pendN   = '0;
      isrN    = '0;
      maskN   = '0;
      offsetN = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      isrQ    <= '0;
      maskQ   <= '0;
      offsetQ <= '0;
    end else begin
      pendQ   <= pendN;
      isrQ    <= isrN;
      maskQ   <= maskN;
      offsetQ <= offsetN;
    end
  end
endmodule

// File: rtl/prioIrqCore.sv
`timescale 1ns/1ps
module prioIrqCore
  import prioIrqPkg::*;
#(
  parameter bit IS_PRIMARY   = 1'b1,
  parameter int CASCADE_LINE = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] reqIn,
  input  logic       wrEn,
  input  logic       addr,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output logic [7:0] rdData,
  input  logic       ackIn,
  output logic [7:0] intVector,
  output logic       intOut
);
  strobeT               stb;
  logic                 rdSelIsr;
  logic                 pollActive;
  logic [DATA_W-1:0]    baseQ;
  logic                 sfnMode;
  logic [NUM_LINES-1:0] pendQ, isrQ, maskQ;
  logic                 hit;
  logic [LINE_W-1:0]    hitLine;
  logic [LINE_W-1:0]    takenLine;

  prioIrqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdEn(rdEn), .ackIn(ackIn), .stb(stb), .rdSelIsr(rdSelIsr),
    .pollActive(pollActive), .baseQ(baseQ), .sfnMode(sfnMode)
  );

  prioIrqDatapath #(.IS_PRIMARY(IS_PRIMARY), .CASCADE_LINE(CASCADE_LINE)) uData (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .stb(stb), .sfnMode(sfnMode),
    .pendQ(pendQ), .isrQ(isrQ), .maskQ(maskQ), .hit(hit), .hitLine(hitLine)
  );

  // spurious selections report the lowest-ranked code
  assign takenLine = hit ? hitLine : '1;
  assign intOut    = hit;
  assign intVector = baseQ | DATA_W'(takenLine);

  always_comb begin
    if (pollActive)    rdData = DATA_W'(takenLine);
    else if (addr)     rdData = maskQ;
    else if (rdSelIsr) rdData = isrQ;
    else               rdData = pendQ;
  end
endmodule

// File: rtl/prioIrqChecker.sv
`timescale 1ns/1ps
module prioIrqChecker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       addr,
  input logic [7:0] wrData,
  input logic       ackIn,
  input logic       intOut,
  input logic [7:0] intVector,
  input logic [7:0] pendQ,
  input logic [7:0] isrQ,
  input logic [7:0] maskQ
);
  // R3: output needs an unmasked pending line
  assert_out_needs_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((pendQ & ~maskQ) != 8'h00));

  // R5: a real acknowledge adds one in-service bit
  assert_ack_adds_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && intOut && !wrEn && !isrQ[2]) |=> ($countones(isrQ) == $past($countones(isrQ)) + 1));

  // R5: a spurious acknowledge presents line 7
  assert_spurious_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !intOut) |-> (intVector[2:0] == 3'd7));

  // R5: a spurious acknowledge leaves the in-service register alone
  assert_spurious_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !intOut && !wrEn) |=> $stable(isrQ));

  // R11: initialisation word empties the state and drops the output
  assert_init_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> (isrQ == 8'h00 && maskQ == 8'h00 && !intOut));
endmodule

bind prioIrqCore prioIrqChecker chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .ackIn(ackIn), .intOut(intOut), .intVector(intVector),
  .pendQ(pendQ), .isrQ(isrQ), .maskQ(maskQ)
);

// File: tb/prioIrqCore_test.sv
`timescale 1ns/1ps
module prioIrqCore_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqIn = '0;
  logic       wrEn = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       ackIn = 1'b0;
  logic [7:0] intVector;
  logic       intOut;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  prioIrqCore uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .ackIn(ackIn),
    .intVector(intVector), .intOut(intOut)
  );

  task automatic check(input string req, input int got, input int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic req(input logic [7:0] v);
    @(negedge clk);
    reqIn = v;
    @(negedge clk);
    reqIn = '0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk);
    ackIn = 1'b1;
    #1 v = intVector;
    @(negedge clk);
    ackIn = 1'b0;
  endtask

  task automatic pollRead(output logic [7:0] v);
    wr(1'b0, 8'h0C);
    rd(1'b0, v);
  endtask

  task automatic setOffset(input int o);
    wr(1'b0, 8'hC0 | 8'((o + 7) & 7));
  endtask

  function automatic int rankOf(input int line, input int off);
    return (line - off) & 7;
  endfunction

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired got 0 expected 1");
    finish();
  end

  initial begin
    logic [7:0] v;
    int expLine;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 intOut", int'(intOut), 0);
    rd(1'b0, v); check("R1 pending", int'(v), 0);
    rd(1'b1, v); check("R1 mask", int'(v), 0);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R1 in-service", int'(v), 0);
    wr(1'b0, 8'h0A);

    // R2 pending latch and hold
    wr(1'b1, 8'hFF);
    req(8'h81);
    rd(1'b0, v); check("R2 pending", int'(v), 8'h81);
    repeat (3) @(negedge clk);
    rd(1'b0, v); check("R2 hold", int'(v), 8'h81);
    check("R4 masked output", int'(intOut), 0);
    wr(1'b1, 8'h00);
    pollRead(v); check("R10 poll first", int'(v), 0);
    pollRead(v); check("R10 poll second", int'(v), 7);
    rd(1'b0, v); check("R2 drained", int'(v), 0);

    // R3 R5 R7 R8 R10 sweep over offset, in-service line and pending line
    for (int o = 0; o < 8; o++) begin
      setOffset(o);
      for (int s = 0; s < 8; s++) begin
        for (int p = 0; p < 8; p++) begin
          req(8'(1 << s));
          ack(v); check("R5 vector line", int'(v), s);
          req(8'(1 << p));
          check("R3 compare", int'(intOut), (rankOf(p, o) < rankOf(s, o)) ? 1 : 0);
          wr(1'b0, 8'h60 | 8'(s));
          check("R7 specific clear", int'(intOut), 1);
          pollRead(v); check("R10 poll line", int'(v), p);
          rd(1'b0, v); check("R10 pending cleared", int'(v), 0);
        end
      end
      wr(1'b0, 8'h0B); rd(1'b0, v); check("R8 in-service untouched", int'(v), 0);
      wr(1'b0, 8'h0A);
    end
    setOffset(0);

    // R4 mask sweep with every line requested
    for (int m = 0; m < 256; m++) begin
      req(8'hFF);
      wr(1'b1, 8'(m));
      rd(1'b1, v); check("R4 mask read", int'(v), m);
      check("R4 output", int'(intOut), (m != 255) ? 1 : 0);
      expLine = 7;
      for (int i = 7; i >= 0; i--) if (((m >> i) & 1) == 0) expLine = i;
      pollRead(v); check("R4 poll under mask", int'(v), expLine);
    end
    wr(1'b1, 8'h00);
    for (int i = 0; i < 8; i++) pollRead(v);
    rd(1'b0, v); check("R4 drain", int'(v), 0);

    // R10 poll with output low returns 7 and disarms
    wr(1'b1, 8'h01);
    req(8'h01);
    pollRead(v); check("R10 idle poll", int'(v), 7);
    rd(1'b0, v); check("R10 disarmed", int'(v), 1);
    wr(1'b1, 8'h00);
    pollRead(v); check("R10 poll after unmask", int'(v), 0);

    // R5 spurious acknowledge
    ack(v); check("R5 spurious vector", int'(v), 7);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R5 spurious no change", int'(v), 0);
    wr(1'b0, 8'h0A);

    // R9 non-specific forms
    req(8'h20); ack(v);
    req(8'h02); ack(v);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R6 select in-service", int'(v), 8'h22);
    wr(1'b0, 8'h20);
    rd(1'b0, v); check("R9 code1 clears best", int'(v), 8'h20);
    wr(1'b0, 8'hA0);
    rd(1'b0, v); check("R9 code5 clears", int'(v), 0);
    wr(1'b0, 8'h0A);
    req(8'h41);
    pollRead(v); check("R9 code5 rotates", int'(v), 6);
    pollRead(v);
    wr(1'b0, 8'hA0);
    req(8'h41);
    pollRead(v); check("R9 empty no rotate", int'(v), 6);
    pollRead(v);

    // R7 code 7 clears and rotates
    setOffset(0);
    req(8'h08); ack(v);
    wr(1'b0, 8'hE3);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R7 code7 clear", int'(v), 0);
    wr(1'b0, 8'h0A);
    req(8'h09);
    pollRead(v); check("R7 code7 rotate", int'(v), 0);
    pollRead(v);

    // R11 initialisation clears everything
    setOffset(3);
    req(8'h10); ack(v);
    wr(1'b1, 8'h80);
    req(8'h40);
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h11);
    check("R11 output dropped", int'(intOut), 0);
    rd(1'b0, v); check("R11 pending cleared", int'(v), 0);
    rd(1'b1, v); check("R11 mask cleared", int'(v), 0);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R11 in-service cleared", int'(v), 0);
    wr(1'b0, 8'h0A);
    wr(1'b1, 8'h00); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    req(8'h81);
    pollRead(v); check("R11 offset cleared", int'(v), 0);
    pollRead(v);

    // R12 sequence variants
    for (int sg = 0; sg < 2; sg++) begin
      for (int f4 = 0; f4 < 2; f4++) begin
        wr(1'b0, 8'h10 | 8'(sg << 1) | 8'(f4));
        wr(1'b1, 8'h5D);
        if (sg == 0) wr(1'b1, 8'hFF);
        if (f4 == 1) wr(1'b1, 8'h00);
        rd(1'b1, v); check("R12 words not mask", int'(v), 0);
        wr(1'b1, 8'hA5);
        rd(1'b1, v); check("R12 back to normal", int'(v), 8'hA5);
        wr(1'b1, 8'h00);
        req(8'h10);
        ack(v); check("R12 base", int'(v), 8'h5C);
        wr(1'b0, 8'h64);
      end
    end

    // R13 special fully nested on
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h10);
    req(8'h04); ack(v);
    req(8'h04);
    check("R13 cascade ignored", int'(intOut), 1);
    wr(1'b0, 8'h64);
    pollRead(v);
    req(8'h04); ack(v);
    req(8'h20);
    check("R13 lower line passes", int'(intOut), 1);
    // R13 off
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h00);
    req(8'h04); ack(v);
    req(8'h20);
    check("R13 off blocks", int'(intOut), 0);

    finish();
  end
endmodule